// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block is the device-side status source of a synthesizable NOR flash model. A command decoder elsewhere in the model signals the start of an embedded program or erase. From the next clock the block owns the read path. Every read cycle during the operation returns a status byte whose toggle bit flips from one read to the next. When the operation completes, the block hands reads back to the array.

The time each operation takes is a cycle-count parameter. There is one count for each case:

- a normal program,
- a program aimed at a protected sector (a short toggle window, no write),
- an erase, which first runs a sector-erase timeout window and then the erase itself,
- an erase whose selected sectors are all protected (a longer toggle window, no erase).

If only some of the selected sectors are protected, the erase runs for its normal length.

A stall input, sampled at the start, models an embedded algorithm that never converges. After a limit count the block raises the exceeded-limit bit and keeps toggling. Only a reset command write returns it to array reads.

Top module: `flash_op_status`

## Requirements
- R1: A `start` pulse while `array_sel` is 1 clears `array_sel` at the next clock edge, so the next read returns status. A read strobe in the same cycle as `start` does not flip the toggle bit.
- R2: Each cycle with `array_sel` at 0 and a read strobe inverts `status[6]` at the next edge. While `array_sel` is 1, `status[6]` holds its value whatever the strobes do.
- R3: A strobe on `rd_oe`, on `rd_ce`, or on both in the same cycle counts as exactly one read cycle.
- R4: A program (`op_kind`=0) with `target_prot`=0 keeps `array_sel` at 0 for exactly `PROG_CYC` cycles. After that, `array_sel` returns to 1 and `status[6]` stops changing.
- R5: A program with `target_prot`=1 keeps `array_sel` at 0 for exactly `PROT_PROG_CYC` cycles, and `stall` is ignored.
- R6: An erase (`op_kind`=1) with `target_prot`=0 lasts `ERASE_WIN_CYC + ERASE_CYC` cycles. `target_prot`=0 covers partly protected selections, and the toggle bit flips throughout.
- R7: An erase with `target_prot`=1 (every selected sector protected) lasts `ERASE_WIN_CYC + PROT_ERASE_CYC` cycles, and `stall` is ignored.
- R8: An operation started with `stall`=1 on an unprotected target sets `status[5]` after `LIMIT_CYC` busy cycles. It stays busy and keeps toggling.
- R9: `reset_cmd` while `status[5]`=1 sets `array_sel` to 1 and clears `status[5]` at the next edge. At any other time `reset_cmd` has no effect.
- R10: `start` while `array_sel` is 0 is ignored. The running operation keeps its length.
- R11: After reset, `array_sel` is 1 and `status` is 8'h00.
- R12: `status` bits 7 and 4 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation-start event (the final write of a command sequence) |
| op_kind | input | 1 | Operation kind: 0 program, 1 erase |
| target_prot | input | 1 | 1 when the program sector, or every selected erase sector, is protected |
| stall | input | 1 | 1 when the embedded algorithm should fail to converge |
| rd_oe | input | 1 | Read cycle delimited by output enable (one pulse per read) |
| rd_ce | input | 1 | Read cycle delimited by chip enable (one pulse per read) |
| reset_cmd | input | 1 | Reset command write |
| status | output | 8 | Status byte: bit 6 toggle, bit 5 exceeded limit, others 0 |
| array_sel | output | 1 | 1 when reads should return array data |

## Verification
The checker watches these rules on every clock:

- A start while idle leaves array mode.
- Every busy read flips bit 6, and idle cycles never do.
- Bit 5 only appears while busy and stays set until a reset command.
- A reset command on an exceeded operation returns to array mode.

The exact length of each operation kind, the protected-target windows, the masking of `stall` on protected targets, and the ignored second start are not visible to a property on the ports. Only the bench's cycle-accurate scenarios can show them.

// File: rtl/flash_op_status_pkg.sv
package flash_op_status_pkg;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;

  localparam int TOGGLE_BIT = 6;
  localparam int LIMIT_BIT  = 5;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_op_dur_sel.sv
module flash_op_dur_sel
  import flash_op_status_pkg::*;
#(
  parameter int CNT_W          = 18,
  parameter int PROG_CYC       = 700,
  parameter int PROT_PROG_CYC  = 200,
  parameter int ERASE_WIN_CYC  = 5000,
  parameter int ERASE_CYC      = 100000,
  parameter int PROT_ERASE_CYC = 10000
) (
  input  op_kind_e         kind,
  input  logic             prot,
  input  logic             stall_req,
  output logic [CNT_W-1:0] dur,
  output logic             stall_eff
);

  localparam int ERASE_TOTAL      = ERASE_WIN_CYC + ERASE_CYC;
  localparam int PROT_ERASE_TOTAL = ERASE_WIN_CYC + PROT_ERASE_CYC;

  always_comb begin
    unique case (kind)
      OP_PROGRAM: dur = prot ? CNT_W'(PROT_PROG_CYC) : CNT_W'(PROG_CYC);
      OP_ERASE:   dur = prot ? CNT_W'(PROT_ERASE_TOTAL) : CNT_W'(ERASE_TOTAL);
      default:    dur = CNT_W'(PROG_CYC);
    endcase
  end

  // A protected target runs no algorithm, so it cannot stall.
  assign stall_eff = stall_req & ~prot;

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W     = 18,
  parameter int LIMIT_CYC = 200000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] dur,
  input  logic             stall_eff,
  input  logic             reset_cmd,
  output logic             busy,
  output logic             exceeded
);

  localparam logic [CNT_W-1:0] LIMIT_LAST = CNT_W'(LIMIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dur_q;
  logic             stall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      exceeded <= 1'b0;
      cnt_q    <= '0;
      dur_q    <= '0;
      stall_q  <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        cnt_q   <= '0;
        dur_q   <= dur;
        stall_q <= stall_eff;
      end
    end else if (exceeded) begin
      if (reset_cmd) begin
        busy     <= 1'b0;
        exceeded <= 1'b0;
      end
    end else if (stall_q) begin
      if (cnt_q == LIMIT_LAST) exceeded <= 1'b1;
      else                     cnt_q    <= cnt_q + 1'b1;
    end else if (cnt_q == dur_q - 1'b1) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/flash_op_toggle.sv
module flash_op_toggle (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic rd_oe,
  input  logic rd_ce,
  output logic tog
);

  // Either delimiter marks one read cycle; both together still mark one.
  logic rd_cycle;
  assign rd_cycle = rd_oe | rd_ce;

  always_ff @(posedge clk) begin
    if (rst)                  tog <= 1'b0;
    else if (busy && rd_cycle) tog <= ~tog;
  end

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flash_op_status_pkg::*;
#(
  parameter int PROG_CYC       = 700,
  parameter int PROT_PROG_CYC  = 200,
  parameter int ERASE_WIN_CYC  = 5000,
  parameter int ERASE_CYC      = 100000,
  parameter int PROT_ERASE_CYC = 10000,
  parameter int LIMIT_CYC      = 200000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       op_kind,
  input  logic       target_prot,
  input  logic       stall,
  input  logic       rd_oe,
  input  logic       rd_ce,
  input  logic       reset_cmd,
  output logic [7:0] status,
  output logic       array_sel
);

  localparam int MAX_CYC = max_int(LIMIT_CYC,
                           max_int(ERASE_WIN_CYC + ERASE_CYC,
                           max_int(ERASE_WIN_CYC + PROT_ERASE_CYC,
                           max_int(PROG_CYC, PROT_PROG_CYC))));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] dur;
  logic             stall_eff;
  logic             busy;
  logic             exceeded;
  logic             tog;

  flash_op_dur_sel #(
    .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .PROT_PROG_CYC(PROT_PROG_CYC),
    .ERASE_WIN_CYC(ERASE_WIN_CYC), .ERASE_CYC(ERASE_CYC),
    .PROT_ERASE_CYC(PROT_ERASE_CYC)
  ) u_dur (
    .kind(op_kind_e'(op_kind)), .prot(target_prot), .stall_req(stall),
    .dur(dur), .stall_eff(stall_eff)
  );

  flash_op_timer #(.CNT_W(CNT_W), .LIMIT_CYC(LIMIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(start), .dur(dur), .stall_eff(stall_eff),
    .reset_cmd(reset_cmd), .busy(busy), .exceeded(exceeded)
  );

  flash_op_toggle u_tog (
    .clk(clk), .rst(rst), .busy(busy), .rd_oe(rd_oe), .rd_ce(rd_ce), .tog(tog)
  );

  always_comb begin
    status             = 8'h00;
    status[TOGGLE_BIT] = tog;
    status[LIMIT_BIT]  = exceeded;
  end

  assign array_sel = ~busy;

endmodule

// File: rtl/flash_op_status_chk.sv
module flash_op_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       rd_oe,
  input logic       rd_ce,
  input logic       reset_cmd,
  input logic [7:0] status,
  input logic       array_sel
);

  p_start_leaves_array_r1: assert property (@(posedge clk) disable iff (rst)
    (array_sel && start) |=> !array_sel);

  p_busy_read_flips_r2: assert property (@(posedge clk) disable iff (rst)
    (!array_sel && (rd_oe || rd_ce)) |=> (status[6] != $past(status[6])));

  p_idle_holds_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    array_sel |=> (status[6] == $past(status[6])));

  p_busy_no_read_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!array_sel && !rd_oe && !rd_ce) |=> (status[6] == $past(status[6])));

  p_limit_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
    status[5] |-> !array_sel);

  p_limit_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (status[5] && !reset_cmd) |=> status[5]);

  p_reset_cmd_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (status[5] && reset_cmd) |=> (array_sel && !status[5]));

endmodule

bind flash_op_status flash_op_status_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .rd_oe(rd_oe), .rd_ce(rd_ce),
  .reset_cmd(reset_cmd), .status(status), .array_sel(array_sel)
);

// File: tb/tb_flash_op_status.sv
module tb_flash_op_status;

  localparam int PG = 6;
  localparam int PP = 3;
  localparam int EW = 4;
  localparam int ER = 12;
  localparam int PE = 5;
  localparam int LM = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 0, op_kind = 0, target_prot = 0, stall = 0;
  logic       rd_oe = 0, rd_ce = 0, reset_cmd = 0;
  logic [7:0] status;
  logic       array_sel;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 0;

  // reference state
  bit m_busy, m_tog, m_exc, m_stall;
  int m_cnt, m_dur;

  always #5 clk = ~clk;

  flash_op_status #(
    .PROG_CYC(PG), .PROT_PROG_CYC(PP), .ERASE_WIN_CYC(EW),
    .ERASE_CYC(ER), .PROT_ERASE_CYC(PE), .LIMIT_CYC(LM)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .op_kind(op_kind),
    .target_prot(target_prot), .stall(stall), .rd_oe(rd_oe), .rd_ce(rd_ce),
    .reset_cmd(reset_cmd), .status(status), .array_sel(array_sel)
  );

  function automatic int exp_dur(input bit k, input bit p);
    if (!k) return p ? PP : PG;
    return EW + (p ? PE : ER);
  endfunction

  function automatic logic [7:0] exp_status();
    return {1'b0, m_tog, m_exc, 5'b00000};
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (status !== exp_status() || array_sel !== !m_busy) begin
      fails++;
      $display("FAIL %s: status=%h array_sel=%b expected status=%h array_sel=%b",
               tag, status, array_sel, exp_status(), !m_busy);
    end
  endtask

  task automatic step(input bit s, input bit k, input bit p, input bit st,
                      input bit oe, input bit ce, input bit rc, input string tag);
    @(negedge clk);
    start = s; op_kind = k; target_prot = p; stall = st;
    rd_oe = oe; rd_ce = ce; reset_cmd = rc;
    if (m_busy && (oe || ce)) m_tog = !m_tog;
    if (!m_busy) begin
      if (s) begin
        m_busy = 1; m_cnt = 0; m_dur = exp_dur(k, p); m_stall = st && !p;
      end
    end else if (m_exc) begin
      if (rc) begin m_busy = 0; m_exc = 0; end
    end else if (m_stall) begin
      if (m_cnt == LM - 1) m_exc = 1; else m_cnt++;
    end else if (m_cnt == m_dur - 1) begin
      m_busy = 0;
    end else m_cnt++;
    @(posedge clk);
    #1;
    check(tag);
  endtask

  // Start an operation, then keep reading until the reference goes idle.
  task automatic run_op(input bit k, input bit p, input bit st, input string tag);
    step(1, k, p, st, 1, 0, 0, tag);
    for (int i = 0; i < 200 && m_busy && !m_exc; i++)
      step(0, k, p, 0, 1, (i % 3) == 0, 0, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_busy = 0; m_tog = 0; m_exc = 0; m_stall = 0; m_cnt = 0; m_dur = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1; check("R11 reset state");

    // R2 / R12: reads while idle change nothing
    step(0, 0, 0, 0, 1, 1, 0, "R2 idle read");
    step(0, 0, 0, 0, 1, 0, 0, "R12 idle read");
    // R9: reset command while idle has no effect
    step(0, 0, 0, 0, 0, 0, 1, "R9 reset idle");

    // R1: read together with start does not toggle
    step(1, 0, 0, 0, 1, 1, 0, "R1 start");
    // R3: oe only, ce only, both
    step(0, 0, 0, 0, 1, 0, 0, "R3 oe read");
    step(0, 0, 0, 0, 0, 1, 0, "R3 ce read");
    step(0, 0, 0, 0, 1, 1, 0, "R3 both read");
    // R10: second start ignored; R9: reset command while busy ignored
    step(1, 1, 0, 0, 0, 0, 0, "R10 start busy");
    step(0, 0, 0, 0, 0, 0, 1, "R9 reset busy");
    while (m_busy) step(0, 0, 0, 0, 1, 0, 0, "R4 program");
    step(0, 0, 0, 0, 1, 0, 0, "R4 after done");

    run_op(0, 1, 1, "R5 protected program");
    step(0, 0, 0, 0, 1, 0, 0, "R5 after done");
    run_op(1, 0, 0, "R6 erase");
    step(0, 0, 0, 0, 0, 1, 0, "R6 after done");
    run_op(1, 1, 1, "R7 protected erase");
    step(0, 0, 0, 0, 1, 0, 0, "R7 after done");

    // R8: stalled program reaches the limit
    run_op(0, 0, 1, "R8 stall");
    step(0, 0, 0, 0, 1, 0, 0, "R8 still toggling");
    step(0, 0, 0, 0, 0, 1, 0, "R8 still toggling");
    step(0, 0, 0, 0, 1, 0, 1, "R9 reset clears");
    step(0, 0, 0, 0, 1, 0, 0, "R9 array after reset");

    // constrained random operations
    for (int n = 0; n < 60; n++) begin
      bit k, p, st;
      k  = 1'($urandom_range(0, 1));
      p  = 1'($urandom_range(0, 1));
      st = ($urandom_range(0, 5) == 0);
      step(1, k, p, st, 1'($urandom_range(0, 1)), 0, 0, "R1 random start");
      for (int i = 0; i < 80 && m_busy; i++) begin
        step(($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             ($urandom_range(0, 9) == 0 || i > 60), "R10 random busy");
      end
      for (int i = 0; i < 3; i++)
        step(0, 0, 0, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), "R2 random idle");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule